// File: doc/BRIEF.md
# Packed-BCD Decimal-Mode Adder/Subtractor

This block is the arithmetic core of an 8-bit processor's add-with-carry and subtract-with-borrow path. It supports a decimal mode that treats each byte as two packed BCD digits and a plain binary mode. One operation is applied per strobe. The unit takes two byte operands, a carry-in, an add/subtract select and a decimal-enable bit. It returns a byte result and four flags: negative, overflow, zero and carry.

Every 8-bit pattern is a legal operand, including digits 0xA to 0xF. Decimal mode applies a fixed nibble-correction sequence, so the result for invalid digits is fully determined. In both modes N and Z follow the final corrected result. The result and flags are registered when `in_valid` is high and appear one clock later together with `out_valid`. When no strobe arrives, the registered values hold.

Top module: `bcd_alu_top`

## Requirements
- R1: While `rst_n` is low and after its release, `out_valid`, `result` and all four flags read 0 until the first strobe has been captured.
- R2: A strobe on `in_valid` at one rising edge sets `out_valid` high after that edge with the new result and flags. A cycle without a strobe drives `out_valid` low and leaves `result` and the flags unchanged, whatever the operand inputs do.
- R3: Binary add (`dec_en`=0, `op_sub`=0) gives `result` = (A + B + carry_in) mod 256. C is bit 8 of that sum. V is set when A and B share a sign bit and the result's bit 7 differs from it.
- R4: Binary subtract (`dec_en`=0, `op_sub`=1) gives `result` = (A − B − (1 − carry_in)) mod 256. C=1 means no borrow occurred, and carry_in=1 means no borrow comes in. V is the signed overflow of that difference.
- R5: Decimal add, low digit: s = A[3:0] + B[3:0] + carry_in. If s ≥ 10, the low digit becomes (s + 6) mod 16 and a carry of 1 goes into the high digit. Otherwise the low digit is s and no carry goes in.
- R6: Decimal add, high digit: h = (A[7:4]·16 + low digit) + B[7:4]·16 + 16·lowcarry, as a 9-bit sum. If h ≥ 256 or (h mod 256) ≥ 0xA0, the result is (h + 0x60) mod 256 and C=1. Otherwise the result is h and C=0. Valid BCD operands always give a valid BCD result.
- R7: Decimal add V is set when A[7] equals B[7] and bit 7 of h (before the 0x60 correction) differs from A[7].
- R8: Decimal subtract: d = A[3:0] − B[3:0] − (1 − carry_in). If d < 0, the low digit is d + 16 and a borrow goes into the high digit. The high difference is (A[7:4]·16 + low digit) − B[7:4]·16 − 16·borrow. If it is negative, 0x60 more is subtracted. If the low digit borrowed, 6 more is subtracted. The result is the final value mod 256. Valid BCD operands always give a valid BCD result.
- R9: Decimal subtract C and V equal those of the binary subtract in R4 for the same operands and carry_in.
- R10: In every mode N equals bit 7 of the final `result`, and Z is 1 exactly when the final `result` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Strobe: capture the current operation |
| op_sub | input | 1 | 0 = add, 1 = subtract |
| dec_en | input | 1 | 1 = packed-BCD mode, 0 = binary mode |
| carry_in | input | 1 | Carry in (for subtract, 1 = no borrow) |
| opnd_a | input | 8 | First operand (minuend for subtract) |
| opnd_b | input | 8 | Second operand (subtrahend for subtract) |
| out_valid | output | 1 | Result registered from a strobe in the previous cycle |
| result | output | 8 | Registered result byte |
| flag_n | output | 1 | Negative flag |
| flag_v | output | 1 | Overflow flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag (for subtract, 1 = no borrow) |

## Verification
The unit holds no state beyond its output register. A wrong low-digit correction, high-digit threshold or borrow decision therefore shows up as a wrong `result` or flag in the very cycle after the strobe. Each such fault hits only certain operand pairs, such as low digits that sum to exactly ten, high sums at 0xA0, or invalid nibbles. The bench sweeps every operand pair in both decimal operations and a dense grid in binary mode, and compares each output against an independent arithmetic model. A register that fails to hold shows up in the first idle cycle after a strobe.

// File: rtl/bcd_alu_pkg.sv
package bcd_alu_pkg;

  localparam int BYTE_W = 8;
  localparam int NIB_W  = BYTE_W / 2;

  typedef struct packed {
    logic [BYTE_W-1:0] res;
    logic              v;
    logic              c;
  } arith_t;

  // Two's-complement add with carry
  function automatic arith_t bin_add(input logic [BYTE_W-1:0] a,
                                     input logic [BYTE_W-1:0] b,
                                     input logic              ci);
    arith_t            o;
    logic [BYTE_W:0]   s;
    s     = {1'b0, a} + {1'b0, b} + {{BYTE_W{1'b0}}, ci};
    o.res = s[BYTE_W-1:0];
    o.c   = s[BYTE_W];
    o.v   = (a[BYTE_W-1] == b[BYTE_W-1]) && (s[BYTE_W-1] != a[BYTE_W-1]);
    return o;
  endfunction

  // Subtract as add of the complement; carry set means no borrow
  function automatic arith_t bin_sub(input logic [BYTE_W-1:0] a,
                                     input logic [BYTE_W-1:0] b,
                                     input logic              ci);
    arith_t            o;
    logic [BYTE_W:0]   s;
    s     = {1'b0, a} + {1'b0, ~b} + {{BYTE_W{1'b0}}, ci};
    o.res = s[BYTE_W-1:0];
    o.c   = s[BYTE_W];
    o.v   = (a[BYTE_W-1] != b[BYTE_W-1]) && (s[BYTE_W-1] != a[BYTE_W-1]);
    return o;
  endfunction

  function automatic logic is_bcd(input logic [BYTE_W-1:0] x);
    return (x[NIB_W-1:0] <= 4'd9) && (x[BYTE_W-1:NIB_W] <= 4'd9);
  endfunction

endpackage

// File: rtl/alu_bin_unit.sv
module alu_bin_unit
  import bcd_alu_pkg::*;
(
  input  logic [BYTE_W-1:0] a,
  input  logic [BYTE_W-1:0] b,
  input  logic              ci,
  output arith_t            add_o,
  output arith_t            sub_o
);
  always_comb begin
    add_o = bin_add(a, b, ci);
    sub_o = bin_sub(a, b, ci);
  end
endmodule

// File: rtl/alu_dec_add.sv
module alu_dec_add
  import bcd_alu_pkg::*;
(
  input  logic [BYTE_W-1:0] a,
  input  logic [BYTE_W-1:0] b,
  input  logic              ci,
  output arith_t            o,
  output logic              lo_fix,
  output logic              hi_fix
);
  logic [NIB_W:0]   lo_sum;
  logic [NIB_W-1:0] lo_dig;
  logic [BYTE_W:0]  hi_sum;

  always_comb begin
    // low digit: binary nibble sum, then +6 wrap when ten or more
    lo_sum = {1'b0, a[NIB_W-1:0]} + {1'b0, b[NIB_W-1:0]} + {{NIB_W{1'b0}}, ci};
    lo_fix = (lo_sum >= 5'd10);
    lo_dig = lo_fix ? (lo_sum[NIB_W-1:0] + 4'd6) : lo_sum[NIB_W-1:0];
    // high digit: A high nibble with corrected low digit, plus B high and carry
    hi_sum = {1'b0, a[BYTE_W-1:NIB_W], lo_dig}
           + {1'b0, b[BYTE_W-1:NIB_W], {NIB_W{1'b0}}}
           + {{NIB_W{1'b0}}, lo_fix, {NIB_W{1'b0}}};
    hi_fix = hi_sum[BYTE_W] || (hi_sum[BYTE_W-1:0] >= 8'hA0);
    o.v    = (a[BYTE_W-1] == b[BYTE_W-1]) && (hi_sum[BYTE_W-1] != a[BYTE_W-1]);
    o.res  = hi_fix ? (hi_sum[BYTE_W-1:0] + 8'h60) : hi_sum[BYTE_W-1:0];
    o.c    = hi_fix;
  end
endmodule

// File: rtl/alu_dec_sub.sv
module alu_dec_sub
  import bcd_alu_pkg::*;
(
  input  logic [BYTE_W-1:0] a,
  input  logic [BYTE_W-1:0] b,
  input  logic              ci,
  output arith_t            o,
  output logic              lo_borrow,
  output logic              hi_borrow
);
  logic [NIB_W:0]    lo_dif;
  logic [BYTE_W:0]   hi_dif;
  logic [BYTE_W-1:0] step;

  always_comb begin
    lo_dif    = {1'b0, a[NIB_W-1:0]} - {1'b0, b[NIB_W-1:0]} - {{NIB_W{1'b0}}, ~ci};
    lo_borrow = lo_dif[NIB_W];
    // the split difference equals the full binary difference
    hi_dif    = {1'b0, a[BYTE_W-1:NIB_W], lo_dif[NIB_W-1:0]}
              - {1'b0, b[BYTE_W-1:NIB_W], {NIB_W{1'b0}}}
              - {{NIB_W{1'b0}}, lo_borrow, {NIB_W{1'b0}}};
    hi_borrow = hi_dif[BYTE_W];
    step      = hi_borrow ? (hi_dif[BYTE_W-1:0] - 8'h60) : hi_dif[BYTE_W-1:0];
    o.res     = lo_borrow ? (step - 8'h06) : step;
    o.c       = ~hi_borrow;
    o.v       = (a[BYTE_W-1] != b[BYTE_W-1]) && (hi_dif[BYTE_W-1] != a[BYTE_W-1]);
  end
endmodule

// File: rtl/bcd_alu_top.sv
module bcd_alu_top
  import bcd_alu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              op_sub,
  input  logic              dec_en,
  input  logic              carry_in,
  input  logic [BYTE_W-1:0] opnd_a,
  input  logic [BYTE_W-1:0] opnd_b,
  output logic              out_valid,
  output logic [BYTE_W-1:0] result,
  output logic              flag_n,
  output logic              flag_v,
  output logic              flag_z,
  output logic              flag_c
);
  arith_t bin_add_w, bin_sub_w, dadd_w, dsub_w, sel_w;
  logic   dadd_lo_fix, dadd_hi_fix, dsub_lo_borrow, dsub_hi_borrow;
  logic   n_next, z_next;

  alu_bin_unit u_bin (
    .a(opnd_a), .b(opnd_b), .ci(carry_in), .add_o(bin_add_w), .sub_o(bin_sub_w)
  );

  alu_dec_add u_dadd (
    .a(opnd_a), .b(opnd_b), .ci(carry_in), .o(dadd_w),
    .lo_fix(dadd_lo_fix), .hi_fix(dadd_hi_fix)
  );

  alu_dec_sub u_dsub (
    .a(opnd_a), .b(opnd_b), .ci(carry_in), .o(dsub_w),
    .lo_borrow(dsub_lo_borrow), .hi_borrow(dsub_hi_borrow)
  );

  always_comb begin
    unique case ({dec_en, op_sub})
      2'b00:   sel_w = bin_add_w;
      2'b01:   sel_w = bin_sub_w;
      2'b10:   sel_w = dadd_w;
      default: sel_w = dsub_w;
    endcase
    n_next = sel_w.res[BYTE_W-1];
    z_next = (sel_w.res == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      flag_n    <= 1'b0;
      flag_v    <= 1'b0;
      flag_z    <= 1'b0;
      flag_c    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result <= sel_w.res;
        flag_n <= n_next;
        flag_v <= sel_w.v;
        flag_z <= z_next;
        flag_c <= sel_w.c;
      end
    end
  end

  // R2: strobe appears one cycle later, idle cycles hold the result
  a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(result) && $stable(flag_c)));
  // R10: flags agree with the registered result
  a_r10_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (flag_z == (result == '0)));
  a_r10_neg: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (flag_n == result[BYTE_W-1]));
  // R6: valid BCD in gives valid BCD out for decimal add
  a_r6_bcd_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (is_bcd(opnd_a) && is_bcd(opnd_b)) |-> is_bcd(dadd_w.res));
  // R8: valid BCD in gives valid BCD out for decimal subtract
  a_r8_bcd_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (is_bcd(opnd_a) && is_bcd(opnd_b)) |-> is_bcd(dsub_w.res));
  // R9: decimal subtract C and V agree with the binary subtractor
  a_r9_flags_match: assert property (@(posedge clk) disable iff (!rst_n)
    (dsub_w.c == bin_sub_w.c) && (dsub_w.v == bin_sub_w.v));
  // R6: a high-digit carry out always forces the decimal correction
  a_r6_carry_fix: assert property (@(posedge clk) disable iff (!rst_n)
    (bin_add_w.c && !dadd_lo_fix) |-> dadd_hi_fix);

endmodule

// File: tb/tb_bcd_alu_top.sv
module tb_bcd_alu_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0, op_sub = 1'b0, dec_en = 1'b0, carry_in = 1'b0;
  logic [7:0] opnd_a = '0, opnd_b = '0;
  logic       out_valid, flag_n, flag_v, flag_z, flag_c;
  logic [7:0] result;
  int         n_checks = 0;
  int         n_errors = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  bcd_alu_top dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sub(op_sub),
    .dec_en(dec_en), .carry_in(carry_in), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .out_valid(out_valid), .result(result), .flag_n(flag_n), .flag_v(flag_v),
    .flag_z(flag_z), .flag_c(flag_c)
  );

  function automatic int wrap8(int x);
    return ((x % 256) + 256) % 256;
  endfunction

  function automatic int sgn(int x);
    return (x > 127) ? x - 256 : x;
  endfunction

  // expected {result, N, V, Z, C}
  function automatic logic [11:0] model(bit sub, bit dec, bit ci, int a, int b);
    int r, c, v, lo, hi, bw, sd;
    c = 0; v = 0;
    if (!sub) begin
      sd = sgn(a) + sgn(b) + ci;
      v  = (sd > 127 || sd < -128) ? 1 : 0;
      if (!dec) begin
        r = a + b + ci; c = (r > 255) ? 1 : 0;
      end else begin
        lo = (a % 16) + (b % 16) + ci; bw = 0;
        if (lo > 9) begin lo = (lo + 6) % 16; bw = 1; end
        hi = (a / 16) * 16 + lo + (b / 16) * 16 + bw * 16;
        v  = (((a ^ hi) & 128) != 0 && ((a ^ b) & 128) == 0) ? 1 : 0;
        if (hi >= 160) begin hi = hi + 96; c = 1; end
        r = hi;
      end
    end else begin
      r  = a - b - (1 - ci);
      c  = (r >= 0) ? 1 : 0;
      sd = sgn(a) - sgn(b) - (1 - ci);
      v  = (sd > 127 || sd < -128) ? 1 : 0;
      if (dec) begin
        lo = (a % 16) - (b % 16) - (1 - ci); bw = 0;
        if (lo < 0) begin lo = lo + 16; bw = 1; end
        hi = (a / 16) * 16 + lo - (b / 16) * 16 - bw * 16;
        if (hi < 0) hi = hi - 96;
        if (bw == 1) hi = hi - 6;
        r = hi;
      end
    end
    r = wrap8(r);
    return {r[7:0], r[7], v[0], (r == 0), c[0]};
  endfunction

  task automatic check(string tag, logic [11:0] got, logic [11:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s: got res=%h nvzc=%b expected res=%h nvzc=%b",
               tag, got[11:4], got[3:0], exp[11:4], exp[3:0]);
    end
  endtask

  // called at a falling edge; returns at the next falling edge after checking
  task automatic run_op(string tag, bit sub, bit dec, bit ci, int a, int b);
    logic [11:0] exp;
    in_valid = 1'b1; op_sub = sub; dec_en = dec; carry_in = ci;
    opnd_a = a[7:0]; opnd_b = b[7:0];
    exp = model(sub, dec, ci, a, b);
    @(negedge clk);
    check(tag, {result, flag_n, flag_v, flag_z, flag_c}, exp);
    if (out_valid !== 1'b1) begin
      n_errors++;
      $display("FAIL R2: out_valid=%b expected 1", out_valid);
    end
  endtask

  task automatic expect_fixed(string tag, bit sub, bit dec, bit ci, int a, int b,
                              logic [7:0] er, logic [3:0] enzvc);
    in_valid = 1'b1; op_sub = sub; dec_en = dec; carry_in = ci;
    opnd_a = a[7:0]; opnd_b = b[7:0];
    @(negedge clk);
    check(tag, {result, flag_n, flag_v, flag_z, flag_c}, {er, enzvc});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset", {result, flag_n, flag_v, flag_z, flag_c}, 12'h000);
    n_checks++;
    if (out_valid !== 1'b0) begin n_errors++; $display("FAIL R1: out_valid=%b expected 0", out_valid); end
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {result, flag_n, flag_v, flag_z, flag_c}, 12'h000);

    // directed corners (flags listed N V Z C)
    expect_fixed("R5 R6 R10 99+00+1", 0, 1, 1, 'h99, 'h00, 8'h00, 4'b0011);
    expect_fixed("R7 79+00+1",        0, 1, 1, 'h79, 'h00, 8'h80, 4'b1100);
    expect_fixed("R5 invalid 0F+00",  0, 1, 0, 'h0F, 'h00, 8'h15, 4'b0000);
    expect_fixed("R8 R9 00-01",       1, 1, 1, 'h00, 'h01, 8'h99, 4'b1000);
    expect_fixed("R8 R9 50-01 ci0",   1, 1, 0, 'h50, 'h01, 8'h48, 4'b0001);
    expect_fixed("R3 7F+01",          0, 0, 0, 'h7F, 'h01, 8'h80, 4'b1100);
    expect_fixed("R4 80-01",          1, 0, 1, 'h80, 'h01, 8'h7F, 4'b0101);

    // R2: idle cycle holds outputs though inputs change
    in_valid = 1'b0; opnd_a = 8'h12; opnd_b = 8'h34; op_sub = 1'b0;
    @(negedge clk);
    check("R2 hold", {result, flag_n, flag_v, flag_z, flag_c}, {8'h7F, 4'b0101});
    n_checks++;
    if (out_valid !== 1'b0) begin n_errors++; $display("FAIL R2: out_valid=%b expected 0", out_valid); end

    // exhaustive decimal sweeps, carry varies with operands
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++)
        run_op("R5 R6 R7 R10 dec add", 0, 1, bit'(a[0] ^ b[1]), a, b);
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++)
        run_op("R8 R9 R10 dec sub", 1, 1, bit'(a[1] ^ b[0]), a, b);
    // binary grid
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b += 5) begin
        run_op("R3 R10 bin add", 0, 0, bit'(a[0] ^ b[0]), a, b);
        run_op("R4 R10 bin sub", 1, 0, bit'(a[2] ^ b[0]), a, b);
      end
    in_valid = 1'b0;
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 199000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
    end
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule